// File: doc/BRIEF.md
# DMA Event and Interrupt Resource Controller

This block holds the signalling resources of a small multi-thread DMA engine: a set of numbered general resources plus one extra abort resource that only the engine's fault logic may raise. A mode register gives each resource its own behaviour. A resource in event mode becomes a flag that is broadcast to the channel threads. The first thread or threads that wait on it consume it. A resource in interrupt mode becomes a sticky interrupt line that stays high until software writes a clear.

The instruction decoder upstream delivers send-event commands as a strobe with a resource number. Each channel thread posts a wait request naming the resource it wants. The block keeps a registered waiting flag for every blocked thread and pulses that thread's wake output when the resource becomes active. Software reaches the mode and clear registers through a simple write port. Two status vectors show the state of every resource: one combines events and interrupts, and the other shows interrupts only.

Top module: `evirq_ctrl`

## Requirements
- R1: Writing with `cfg_sel`=0 loads `cfg_wdata` into the mode register. Bit n = 0 puts resource n in event mode and 1 puts it in interrupt mode. The new mode applies to commands from the next cycle on.
- R2: A send-event command for general resource n in event mode sets event n at the next edge: `raw_status_o[n]`=1, while `irq_o[n]` and `int_status_o[n]` stay 0.
- R3: A send-event command for resource n in interrupt mode drives `irq_o[n]` and `int_status_o[n]` high at the next edge. They stay high, with no further command, until a clear.
- R4: While a thread is waiting on resource n and event n is active, the thread's `wake_o` bit is high for one cycle. At the end of that cycle event n is cleared and the thread stops waiting.
- R5: Writing with `cfg_sel`=1 (write-one-to-clear) lowers `irq_o[n]` at the next edge for every set bit n whose resource is in interrupt mode.
- R6: A clear for a resource in event mode leaves that resource's event state and status unchanged.
- R7: A send-event command whose number is the abort index (8 by default) or larger is rejected and changes no resource.
- R8: A pulse on `fault_abort` raises the abort resource (index 8 by default), as an event or as an interrupt according to its mode bit.
- R9: When a send-event and a clear for the same interrupt-mode resource fall in one cycle, the line ends high.
- R10: All threads waiting on the same active event wake in the same cycle, and the event is consumed once: a thread that waits on it afterwards stays blocked.
- R11: A thread that requests a wait on an inactive event shows `waiting_o`=1 from the next edge. The flag holds, with `wake_o`=0, until the event is sent.
- R12: Reset clears all events, all interrupt lines, the mode register and all waiting flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = mode register, 1 = interrupt clear |
| cfg_wdata | input | NUM_RES+1 | Write data, one bit per resource |
| sev_valid | input | 1 | Send-event command strobe |
| sev_id | input | IDW | Resource number of the send-event command |
| fault_abort | input | 1 | Internal fault raising the abort resource |
| wfe_req | input | NUM_THR | Per-thread wait request |
| wfe_id | input | NUM_THR*IDW | Per-thread resource number to wait on |
| irq_o | output | NUM_RES+1 | Interrupt lines |
| raw_status_o | output | NUM_RES+1 | Event active or interrupt high |
| int_status_o | output | NUM_RES+1 | Interrupt high |
| wake_o | output | NUM_THR | Per-thread resume pulse |
| waiting_o | output | NUM_THR | Per-thread blocked flag |

## Verification
The bench issues a clear to an event-mode resource. A design that applied the clear regardless of mode would lose the pending event. It lines up a send and a clear on one interrupt line in the same cycle; a design with the wrong priority would drop the fresh interrupt. It wakes two threads from one send and then adds a late waiter: a design that consumed per thread, or not at all, would either leave a waiter asleep or wake the late thread. Sends aimed at the abort index and above are checked to leave all status untouched, because a missing range check would raise the abort resource from software.

// File: rtl/evirq_pkg.sv
// Package: shared select codes for the event-interrupt resource controller.
// Assumes: only the register select code is shared across modules.
package evirq_pkg;
    typedef enum logic {
        CFG_MODE  = 1'b0,
        CFG_CLEAR = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/evirq_cfg.sv
// Module: evirq_cfg
// Holds the per-resource mode register and turns clear writes into a
// one-cycle clear request vector.
// Assumes: write data is one bit per resource; clear is write-one-to-clear.
module evirq_cfg
    import evirq_pkg::*;
#(
    parameter int NRES = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [NRES-1:0] cfg_wdata,
    output logic [NRES-1:0] mode_q,
    output logic [NRES-1:0] clr_req
);
    // Mode register: 0 = event, 1 = interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (cfg_we && cfg_sel == CFG_MODE)
            mode_q <= cfg_wdata;
    end

    // Clear request decode, valid in the write cycle only.
    always_comb begin
        clr_req = (cfg_we && cfg_sel == CFG_CLEAR) ? cfg_wdata : '0;
    end
endmodule

// File: rtl/evirq_hit_dec.sv
// Module: evirq_hit_dec
// Decodes send-event commands and the internal fault into a per-resource
// raise vector. Commands naming the abort index or above are dropped.
// Assumes: the abort resource sits at index NUM_RES.
module evirq_hit_dec #(
    parameter int NUM_RES = 8,
    parameter int IDW     = 4,
    localparam int NRES   = NUM_RES + 1
) (
    input  logic            sev_valid,
    input  logic [IDW-1:0]  sev_id,
    input  logic            fault_abort,
    output logic [NRES-1:0] hit
);
    // Numbered resources come from software commands only.
    for (genvar n = 0; n < NUM_RES; n++) begin : g_hit
        assign hit[n] = sev_valid && (sev_id == IDW'(n));
    end
    // Abort resource comes from fault logic only.
    assign hit[NUM_RES] = fault_abort;
endmodule

// File: rtl/evirq_res_bank.sv
// Module: evirq_res_bank
// One state slice per resource: an event flag and an interrupt line.
// A raise lands in one of them by mode; clears act only on interrupt-mode
// lines; consumption by waiting threads acts only on the event flag.
// Assumes: a raise wins over a clear or a consumption in the same cycle.
module evirq_res_bank #(
    parameter int NRES = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NRES-1:0] hit,
    input  logic [NRES-1:0] mode_q,
    input  logic [NRES-1:0] clr_req,
    input  logic [NRES-1:0] consumed,
    output logic [NRES-1:0] evt_q,
    output logic [NRES-1:0] irq_q
);
    for (genvar n = 0; n < NRES; n++) begin : g_res
        logic set_evt, set_irq, clr_irq;

        // Route the raise by mode and qualify the clear by mode.
        always_comb begin
            set_evt = hit[n] && !mode_q[n];
            set_irq = hit[n] && mode_q[n];
            clr_irq = clr_req[n] && mode_q[n];
        end

        // Event flag: set by a raise, dropped when a waiter consumes it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt_q[n] <= 1'b0;
            else
                evt_q[n] <= (evt_q[n] && !consumed[n]) || set_evt;
        end

        // Interrupt line: sticky until an interrupt-mode clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                irq_q[n] <= 1'b0;
            else
                irq_q[n] <= (irq_q[n] && !clr_irq) || set_irq;
        end

        assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q[n] && !clr_req[n] |=> irq_q[n]);

        assert_event_clear_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[n] && !mode_q[n] && !hit[n] && !consumed[n]
            |=> $stable(evt_q[n]) && $stable(irq_q[n]));

        assert_wake_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            consumed[n] && !hit[n] |=> !evt_q[n]);

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            hit[n] && mode_q[n] && clr_req[n] |=> irq_q[n]);
    end
endmodule

// File: rtl/evirq_wait.sv
// Module: evirq_wait
// Per-thread wait trackers. A request latches the awaited resource and a
// waiting flag; the thread wakes when that event is active, and every
// resource woken on is reported as consumed (once, however many waiters).
// Assumes: requests from a thread already waiting are ignored.
module evirq_wait #(
    parameter int NUM_THR = 8,
    parameter int NRES    = 9,
    parameter int IDW     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THR-1:0]     wfe_req,
    input  logic [NUM_THR*IDW-1:0] wfe_id,
    input  logic [NRES-1:0]        evt_q,
    output logic [NUM_THR-1:0]     wake,
    output logic [NUM_THR-1:0]     busy_q,
    output logic [NRES-1:0]        consumed
);
    localparam int IDSPAN = 2 ** IDW;

    logic [IDSPAN-1:0]  evt_pad;
    logic [IDW-1:0]     id_q [NUM_THR];

    // Widen the event vector so any id value indexes safely.
    assign evt_pad = IDSPAN'(evt_q);

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        // Waiting flag and awaited id for thread t.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[t] <= 1'b0;
                id_q[t]   <= '0;
            end else if (busy_q[t]) begin
                if (wake[t])
                    busy_q[t] <= 1'b0;
            end else if (wfe_req[t]) begin
                busy_q[t] <= 1'b1;
                id_q[t]   <= wfe_id[t*IDW +: IDW];
            end
        end

        // Resume when the awaited event is active.
        assign wake[t] = busy_q[t] && evt_pad[id_q[t]];

        assert_blocked_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q[t] && !wake[t] |=> busy_q[t]);
    end

    // Collect the resources consumed this cycle.
    always_comb begin
        consumed = '0;
        for (int t = 0; t < NUM_THR; t++)
            for (int n = 0; n < NRES; n++)
                if (wake[t] && id_q[t] == IDW'(n))
                    consumed[n] = 1'b1;
    end
endmodule

// File: rtl/evirq_ctrl.sv
// Module: evirq_ctrl (top)
// Event-interrupt resource controller for a multi-thread DMA engine:
// NUM_RES numbered resources plus one abort resource at index NUM_RES,
// each run as a broadcast event or a sticky interrupt line.
// Assumes: synchronous active-low reset; wait ids above the abort index
// never wake.
module evirq_ctrl #(
    parameter int NUM_RES = 8,
    parameter int NUM_THR = 8,
    localparam int NRES   = NUM_RES + 1,
    localparam int IDW    = $clog2(NRES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_sel,
    input  logic [NRES-1:0]        cfg_wdata,
    input  logic                   sev_valid,
    input  logic [IDW-1:0]         sev_id,
    input  logic                   fault_abort,
    input  logic [NUM_THR-1:0]     wfe_req,
    input  logic [NUM_THR*IDW-1:0] wfe_id,
    output logic [NRES-1:0]        irq_o,
    output logic [NRES-1:0]        raw_status_o,
    output logic [NRES-1:0]        int_status_o,
    output logic [NUM_THR-1:0]     wake_o,
    output logic [NUM_THR-1:0]     waiting_o
);
    logic [NRES-1:0] mode_q, clr_req, hit, consumed, evt_q, irq_q;

    evirq_cfg #(.NRES(NRES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mode_q(mode_q), .clr_req(clr_req)
    );

    evirq_hit_dec #(.NUM_RES(NUM_RES), .IDW(IDW)) u_hit (
        .sev_valid(sev_valid), .sev_id(sev_id), .fault_abort(fault_abort),
        .hit(hit)
    );

    evirq_res_bank #(.NRES(NRES)) u_bank (
        .clk(clk), .rst_n(rst_n), .hit(hit), .mode_q(mode_q),
        .clr_req(clr_req), .consumed(consumed), .evt_q(evt_q), .irq_q(irq_q)
    );

    evirq_wait #(.NUM_THR(NUM_THR), .NRES(NRES), .IDW(IDW)) u_wait (
        .clk(clk), .rst_n(rst_n), .wfe_req(wfe_req), .wfe_id(wfe_id),
        .evt_q(evt_q), .wake(wake_o), .busy_q(waiting_o), .consumed(consumed)
    );

    // Status views.
    assign irq_o        = irq_q;
    assign int_status_o = irq_q;
    assign raw_status_o = evt_q | irq_q;

    assert_abort_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sev_valid && sev_id >= IDW'(NUM_RES) && !fault_abort && cfg_we == 1'b0
        && wake_o == '0 |=> $stable(raw_status_o));
endmodule

// File: tb/evirq_ctrl_tb.sv
`timescale 1ns/1ps
module evirq_ctrl_tb;
    localparam int NR  = 9;
    localparam int NT  = 8;
    localparam int IDW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [NR-1:0] cfg_wdata = '0;
    logic sev_valid = 1'b0;
    logic [IDW-1:0] sev_id = '0;
    logic fault_abort = 1'b0;
    logic [NT-1:0] wfe_req = '0;
    logic [NT*IDW-1:0] wfe_id = '0;
    logic [NR-1:0] irq_o, raw_status_o, int_status_o;
    logic [NT-1:0] wake_o, waiting_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    evirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sev_valid(sev_valid), .sev_id(sev_id),
        .fault_abort(fault_abort), .wfe_req(wfe_req), .wfe_id(wfe_id),
        .irq_o(irq_o), .raw_status_o(raw_status_o), .int_status_o(int_status_o),
        .wake_o(wake_o), .waiting_o(waiting_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge and clear all strobes; lands at a falling edge.
    task automatic step();
        @(negedge clk);
        cfg_we = 1'b0; sev_valid = 1'b0; fault_abort = 1'b0; wfe_req = '0;
    endtask

    task automatic do_send(input int id);
        sev_valid = 1'b1; sev_id = IDW'(id); step();
    endtask

    task automatic do_cfg(input logic sel, input logic [NR-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; step();
    endtask

    task automatic do_wait(input int t, input int id);
        wfe_req[t] = 1'b1; wfe_id[t*IDW +: IDW] = IDW'(id);
    endtask

    task automatic t_reset();
        chk("R12 irq", irq_o, 0);
        chk("R12 raw", raw_status_o, 0);
        chk("R12 int", int_status_o, 0);
        chk("R12 waiting", waiting_o, 0);
        chk("R12 wake", wake_o, 0);
    endtask

    task automatic t_event_and_wake();
        do_send(3);
        chk("R2 raw", raw_status_o, 32'h008);
        chk("R2 irq", irq_o, 0);
        chk("R2 int", int_status_o, 0);
        do_wait(2, 3); step();
        chk("R4 wake", wake_o, 32'h04);
        step();
        chk("R4 consumed", raw_status_o, 0);
        chk("R4 resumed", waiting_o, 0);
    endtask

    task automatic t_irq_mode();
        do_cfg(1'b0, 9'h020);
        do_send(5);
        chk("R1 R3 irq", irq_o, 32'h020);
        chk("R3 int", int_status_o, 32'h020);
        repeat (4) step();
        chk("R3 sticky", irq_o, 32'h020);
        do_cfg(1'b1, 9'h020);
        chk("R5 cleared", irq_o, 0);
        chk("R5 raw", raw_status_o, 0);
    endtask

    task automatic t_clear_event();
        do_send(1);
        do_cfg(1'b1, 9'h002);
        chk("R6 event kept", raw_status_o, 32'h002);
        chk("R6 no irq", irq_o, 0);
        do_wait(0, 1); step(); step();
        chk("R6 tidy", raw_status_o, 0);
    endtask

    task automatic t_abort();
        do_send(8);
        chk("R7 abort id", raw_status_o, 0);
        do_send(13);
        chk("R7 out of range", raw_status_o, 0);
        fault_abort = 1'b1; step();
        chk("R8 abort event", raw_status_o, 32'h100);
        chk("R8 no irq", irq_o, 0);
        do_wait(1, 8); step(); step();
        do_cfg(1'b0, 9'h120);
        fault_abort = 1'b1; step();
        chk("R8 abort irq", irq_o, 32'h100);
        do_cfg(1'b1, 9'h100);
        chk("R8 abort clear", irq_o, 0);
    endtask

    task automatic t_set_wins();
        sev_valid = 1'b1; sev_id = 4'd5;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 9'h020;
        step();
        chk("R9 set wins", irq_o, 32'h020);
        do_cfg(1'b1, 9'h020);
        do_cfg(1'b0, 9'h000);
    endtask

    task automatic t_multi_and_block();
        do_wait(4, 2); do_wait(6, 2); step();
        chk("R11 waiting", waiting_o, 32'h50);
        do_send(2);
        chk("R10 both wake", wake_o, 32'h50);
        step();
        chk("R10 consumed once", raw_status_o, 0);
        do_wait(7, 2); step();
        chk("R10 late waiter blocked", wake_o, 0);
        repeat (5) step();
        chk("R11 hold", waiting_o, 32'h80);
        chk("R11 no wake", wake_o, 0);
        do_send(2);
        chk("R11 woken", wake_o, 32'h80);
        step();
        chk("R11 released", waiting_o, 0);
    endtask

    task automatic t_reset_after();
        do_cfg(1'b0, 9'h004);
        do_send(2); do_send(3);
        do_wait(0, 6); step();
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        t_reset();
        do_send(2);
        chk("R12 mode cleared", irq_o, 0);
        chk("R12 event mode", raw_status_o, 32'h004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_event_and_wake();
        t_irq_mode();
        t_clear_event();
        t_abort();
        t_set_wins();
        t_multi_and_block();
        t_reset_after();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule